// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the 8-bit arithmetic and logic stage of a small accumulator-style processor core. On every cycle where `issue_i` is high it takes an operation code, the working-register value, a second operand (either the addressed file-register byte or an 8-bit literal), a bit index and the current status flags. One clock edge later it presents an 8-bit result, the destination select for that result, the updated five-bit status and, for multiplies, a 16-bit product.

Each operation class updates its own subset of the flags and passes the other flags through unchanged. The decoder upstream supplies the operation code. The write-back stage downstream uses `dest_o` to decide whether the result goes to the working register or to the file register. Instruction fetch, decode, banking and the write-back itself sit outside this block.

Top module: `byte_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, `done_o` is 0 and `res_o`, `dest_o`, `flags_o` and `prod_o` are all zero until the first issued operation.
- R2: An operation issued with `issue_i`=1 at a rising edge appears on the outputs after that edge, with `done_o`=1. A cycle with `issue_i`=0 drives `done_o` to 0 and leaves `res_o`, `dest_o`, `flags_o` and `prod_o` unchanged.
- R3: The second operand B is `lit_i` when `use_lit_i`=1 and `freg_i` otherwise. The flag vector is ordered [0]=C, [1]=DC, [2]=Z, [3]=OV, [4]=N.
- R4: The add codes are 0 (W+B) and 1 (W+B+C). Both update all five flags: C is the carry out of bit 7, DC is the carry out of bit 3, OV is the signed two's-complement overflow, Z is set when the result is zero, and N is result bit 7.
- R5: The subtract codes are 2 (B−W), 3 (B−W−borrow) and 4 (W−B−borrow). Here borrow = NOT C, C=1 means no borrow, and DC=1 means no borrow out of the low nibble. All five flags are updated.
- R6: Code 5 (B+1), code 6 (B−1) and code 7 (negate, 0−B as invert-and-add-one) update all five flags, using the same carry rules as add and subtract.
- R7: Code 8 (W AND B), code 9 (W OR B), code 10 (W XOR B), code 11 (NOT B), code 12 (move B), code 13 (rotate B left without carry) and code 14 (rotate B right without carry) update only Z and N.
- R8: Code 15 (rotate left through carry) and code 16 (rotate right through carry) shift the old C into the vacated bit, load the bit shifted out into C, and update Z and N. DC and OV are kept.
- R9: Code 17 swaps the two nibbles of B (0xAB gives 0xBA) and leaves all flags unchanged.
- R10: Code 18 sets, code 19 clears and code 20 toggles bit `bit_sel_i` (0..7) of B, with no flag change. For example, clearing bit 2 of 0xFF gives 0xFB.
- R11: Code 21 loads `prod_o` with the unsigned product W×B and `res_o` with its low byte, with no flag change. `prod_o` changes on no other operation.
- R12: Code 22 decimal-adjusts W. It adds 0x06 if the low nibble is above 9 or DC=1. It then adds 0x60 if the resulting high nibble is above 9, C=1, or the first step carried. C is set on any such carry or when it was already 1. Only C changes.
- R13: `dest_o` repeats `dest_i` (0 = working register, 1 = file register), except that code 22 always gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| use_lit_i | input | 1 | Select literal as operand B |
| dest_i | input | 1 | Destination select for the result |
| wreg_i | input | 8 | Working register value |
| freg_i | input | 8 | File register operand |
| lit_i | input | 8 | Literal operand |
| bit_sel_i | input | 3 | Bit index for the bit operations |
| flags_i | input | 5 | Current status {N,OV,Z,DC,C} |
| done_o | output | 1 | Outputs hold a fresh result |
| res_o | output | 8 | Result byte |
| dest_o | output | 1 | Destination select for the result |
| flags_o | output | 5 | Updated status |
| prod_o | output | 16 | Last multiply product |

## Verification
Every output is registered, so a fault in any internal path shows at the ports on the very next edge after the faulty operation is issued. There is no hidden state that could carry an error forward without it appearing on the ports. A wrong carry-in or inverted operand in the shared adder appears as a wrong result together with wrong C, DC or OV. A wrong flag mask instead leaves the result correct while a flag that should have passed through, or should have changed, takes the wrong value. The comparison therefore always covers the full flag vector and the destination as well as the result byte. The multiply register holds its value between products, so it is also compared on the cycles after non-multiply operations.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBB  = 5'd3,
    OP_RSUBB = 5'd4,
    OP_INC   = 5'd5,
    OP_DEC   = 5'd6,
    OP_NEG   = 5'd7,
    OP_AND   = 5'd8,
    OP_OR    = 5'd9,
    OP_XOR   = 5'd10,
    OP_COM   = 5'd11,
    OP_MOV   = 5'd12,
    OP_ROLN  = 5'd13,
    OP_RORN  = 5'd14,
    OP_ROLC  = 5'd15,
    OP_RORC  = 5'd16,
    OP_SWAP  = 5'd17,
    OP_BSET  = 5'd18,
    OP_BCLR  = 5'd19,
    OP_BTOG  = 5'd20,
    OP_MUL   = 5'd21,
    OP_DADJ  = 5'd22
  } op_e;

  localparam int FL_C  = 0;
  localparam int FL_DC = 1;
  localparam int FL_Z  = 2;
  localparam int FL_OV = 3;
  localparam int FL_N  = 4;

  function automatic logic uses_adder(op_e op);
    return op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_RSUBB,
                      OP_INC, OP_DEC, OP_NEG};
  endfunction

  function automatic logic sets_zn_only(op_e op);
    return op inside {OP_AND, OP_OR, OP_XOR, OP_COM, OP_MOV, OP_ROLN, OP_RORN};
  endfunction

  function automatic logic is_rot_carry(op_e op);
    return op inside {OP_ROLC, OP_RORC};
  endfunction

  function automatic logic keeps_flags(op_e op);
    return op inside {OP_SWAP, OP_BSET, OP_BCLR, OP_BTOG, OP_MUL};
  endfunction

endpackage

// File: rtl/byte_adder.sv
module byte_adder #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          half_cout,
  output logic          ovf
);
  localparam int NIB = DW / 2;

  logic [DW:0]  full;
  logic [NIB:0] low;

  always_comb begin
    full      = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    low       = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    sum       = full[DW-1:0];
    cout      = full[DW];
    half_cout = low[NIB];
    ovf       = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/byte_shuffler.sv
module byte_shuffler
  import byte_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = $clog2(DW)
) (
  input  op_e           op,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic [BW-1:0] bsel,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int NIB = DW / 2;

  logic [DW-1:0] mask;
  logic [DW-1:0] swapped;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (bsel == BW'(i));
  end

  assign swapped = {b[NIB-1:0], b[DW-1:NIB]};

  always_comb begin
    res  = b;
    cout = cin;
    case (op)
      OP_AND:  res = w & b;
      OP_OR:   res = w | b;
      OP_XOR:  res = w ^ b;
      OP_COM:  res = ~b;
      OP_MOV:  res = b;
      OP_ROLN: res = {b[DW-2:0], b[DW-1]};
      OP_RORN: res = {b[0], b[DW-1:1]};
      OP_ROLC: begin res = {b[DW-2:0], cin}; cout = b[DW-1]; end
      OP_RORC: begin res = {cin, b[DW-1:1]}; cout = b[0];    end
      OP_SWAP: res = swapped;
      OP_BSET: res = b | mask;
      OP_BCLR: res = b & ~mask;
      OP_BTOG: res = b ^ mask;
      default: res = b;
    endcase
  end
endmodule

// File: rtl/bcd_adjust.sv
module bcd_adjust #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] w,
  input  logic          c_in,
  input  logic          dc_in,
  output logic [DW-1:0] res,
  output logic          c_out
);
  localparam int NIB = DW / 2;

  logic [DW:0] step1;
  logic [DW:0] step2;
  logic        lo_fix;
  logic        hi_fix;

  always_comb begin
    lo_fix = (w[NIB-1:0] > NIB'(9)) || dc_in;
    step1  = {1'b0, w} + (lo_fix ? (DW+1)'(6) : '0);
    hi_fix = (step1[DW-1:NIB] > NIB'(9)) || c_in || step1[DW];
    step2  = {1'b0, step1[DW-1:0]} + (hi_fix ? (DW+1)'(8'h60) : '0);
    res    = step2[DW-1:0];
    c_out  = c_in | step1[DW] | step2[DW];
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_i,
  input  logic [4:0]            op_i,
  input  logic                  use_lit_i,
  input  logic                  dest_i,
  input  logic [DW-1:0]         wreg_i,
  input  logic [DW-1:0]         freg_i,
  input  logic [DW-1:0]         lit_i,
  input  logic [$clog2(DW)-1:0] bit_sel_i,
  input  logic [FW-1:0]         flags_i,
  output logic                  done_o,
  output logic [DW-1:0]         res_o,
  output logic                  dest_o,
  output logic [FW-1:0]         flags_o,
  output logic [2*DW-1:0]       prod_o
);
  localparam int PW = 2 * DW;
  localparam int BW = $clog2(DW);

  op_e           op;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] add_a, add_b, add_sum;
  logic          add_ci, add_c, add_dc, add_ov;
  logic [DW-1:0] sh_res;
  logic          sh_c;
  logic [DW-1:0] bcd_res;
  logic          bcd_c;
  logic [PW-1:0] product;
  logic [DW-1:0] res_d;
  logic [FW-1:0] flags_d;
  logic          dest_d;

  assign op      = op_e'(op_i);
  assign opnd_b  = use_lit_i ? lit_i : freg_i;
  assign product = PW'(wreg_i) * PW'(opnd_b);

  always_comb begin
    add_a  = opnd_b;
    add_b  = '0;
    add_ci = 1'b0;
    case (op)
      OP_ADD:   begin add_a = wreg_i; add_b = opnd_b;  add_ci = 1'b0;          end
      OP_ADDC:  begin add_a = wreg_i; add_b = opnd_b;  add_ci = flags_i[FL_C]; end
      OP_SUB:   begin add_a = opnd_b; add_b = ~wreg_i; add_ci = 1'b1;          end
      OP_SUBB:  begin add_a = opnd_b; add_b = ~wreg_i; add_ci = flags_i[FL_C]; end
      OP_RSUBB: begin add_a = wreg_i; add_b = ~opnd_b; add_ci = flags_i[FL_C]; end
      OP_INC:   begin add_a = opnd_b; add_b = '0;      add_ci = 1'b1;          end
      OP_DEC:   begin add_a = opnd_b; add_b = '1;      add_ci = 1'b0;          end
      OP_NEG:   begin add_a = '0;     add_b = ~opnd_b; add_ci = 1'b1;          end
      default:  ;
    endcase
  end

  byte_adder #(.DW(DW)) u_add (
    .a(add_a), .b(add_b), .cin(add_ci),
    .sum(add_sum), .cout(add_c), .half_cout(add_dc), .ovf(add_ov)
  );

  byte_shuffler #(.DW(DW), .BW(BW)) u_shuf (
    .op(op), .w(wreg_i), .b(opnd_b), .cin(flags_i[FL_C]), .bsel(bit_sel_i),
    .res(sh_res), .cout(sh_c)
  );

  bcd_adjust #(.DW(DW)) u_bcd (
    .w(wreg_i), .c_in(flags_i[FL_C]), .dc_in(flags_i[FL_DC]),
    .res(bcd_res), .c_out(bcd_c)
  );

  always_comb begin
    res_d   = sh_res;
    flags_d = flags_i;
    dest_d  = dest_i;
    if (uses_adder(op)) begin
      res_d          = add_sum;
      flags_d[FL_C]  = add_c;
      flags_d[FL_DC] = add_dc;
      flags_d[FL_OV] = add_ov;
      flags_d[FL_Z]  = (add_sum == '0);
      flags_d[FL_N]  = add_sum[DW-1];
    end else if (sets_zn_only(op)) begin
      flags_d[FL_Z]  = (sh_res == '0);
      flags_d[FL_N]  = sh_res[DW-1];
    end else if (is_rot_carry(op)) begin
      flags_d[FL_C]  = sh_c;
      flags_d[FL_Z]  = (sh_res == '0);
      flags_d[FL_N]  = sh_res[DW-1];
    end else if (op == OP_DADJ) begin
      res_d          = bcd_res;
      flags_d[FL_C]  = bcd_c;
      dest_d         = 1'b0;
    end else if (op == OP_MUL) begin
      res_d          = product[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      res_o   <= '0;
      dest_o  <= 1'b0;
      flags_o <= '0;
      prod_o  <= '0;
    end else begin
      done_o <= issue_i;
      if (issue_i) begin
        res_o   <= res_d;
        dest_o  <= dest_d;
        flags_o <= flags_d;
        if (op == OP_MUL) prod_o <= product;
      end
    end
  end

  // Checks on the registered outputs against the operands sampled one cycle earlier
  assert_done_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> done_o);
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!done_o && $stable(res_o) && $stable(flags_o) && $stable(prod_o)));
  assert_adder_zn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && uses_adder(op)) |=>
      (flags_o[FL_N] == res_o[DW-1]) && (flags_o[FL_Z] == (res_o == '0)));
  assert_logic_keeps_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && sets_zn_only(op)) |=>
      (flags_o[FL_C] == $past(flags_i[FL_C])) && (flags_o[FL_OV] == $past(flags_i[FL_OV]))
      && (flags_o[FL_DC] == $past(flags_i[FL_DC])));
  assert_rotc_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op == OP_ROLC) |=> (flags_o[FL_C] == $past(opnd_b[DW-1]))
      && (res_o[0] == $past(flags_i[FL_C])));
  assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op == OP_SWAP) |=> (flags_o == $past(flags_i))
      && (res_o[DW/2-1:0] == $past(opnd_b[DW-1:DW/2])));
  assert_bit_ops_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op inside {OP_BSET, OP_BCLR, OP_BTOG}) |=>
      (flags_o == $past(flags_i)) && ($countones(res_o ^ $past(opnd_b)) <= 1));
  assert_mul_no_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op == OP_MUL) |=> (flags_o == $past(flags_i))
      && (res_o == prod_o[DW-1:0]));
  assert_dadj_dest_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op == OP_DADJ) |=> !dest_o);
endmodule

// File: tb/sim_byte_alu.sv
module sim_byte_alu;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic        use_lit_i = 1'b0;
  logic        dest_i = 1'b0;
  logic [7:0]  wreg_i = '0, freg_i = '0, lit_i = '0;
  logic [2:0]  bit_sel_i = '0;
  logic [4:0]  flags_i = '0;
  logic        done_o;
  logic [7:0]  res_o;
  logic        dest_o;
  logic [4:0]  flags_o;
  logic [15:0] prod_o;

  int checks = 0;
  int errors = 0;
  logic [7:0]  e_res = '0;
  logic [4:0]  e_fl = '0;
  logic        e_dest = 1'b0;
  logic [15:0] e_prod = '0;
  logic [31:0] lf = 32'h1ACE_B00C;

  byte_alu u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic string tag_of(int op);
    if (op <= 1) return "R4";
    if (op <= 4) return "R5";
    if (op <= 7) return "R6";
    if (op <= 14) return "R7";
    if (op <= 16) return "R8";
    if (op == 17) return "R9";
    if (op <= 20) return "R10";
    if (op == 21) return "R11";
    return "R12";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Reference model: plain integer arithmetic; flags as ints then packed {N,OV,Z,DC,C}
  task automatic model(input int op, input int w, input int b, input int bs, input int fl_in, input int dst);
    int c = fl_in & 1, dc = (fl_in >> 1) & 1, z = (fl_in >> 2) & 1, ov = (fl_in >> 3) & 1, n = (fl_in >> 4) & 1;
    int r = b, x = 0, y = 0, k = 0, t = 0, s = 0, lo = 0, cy1 = 0;
    bit arith = 0, zn = 0, add = 0;
    case (op)
      0: begin x = w; y = b; k = 0; add = 1; arith = 1; end
      1: begin x = w; y = b; k = c; add = 1; arith = 1; end
      2: begin x = b; y = w; k = 0; arith = 1; end
      3: begin x = b; y = w; k = 1 - c; arith = 1; end
      4: begin x = w; y = b; k = 1 - c; arith = 1; end
      5: begin x = b; y = 1; k = 0; add = 1; arith = 1; end
      6: begin x = b; y = 1; k = 0; arith = 1; end
      7: begin x = 0; y = b; k = 0; arith = 1; end
      8: begin r = w & b; zn = 1; end
      9: begin r = w | b; zn = 1; end
      10: begin r = w ^ b; zn = 1; end
      11: begin r = 255 - b; zn = 1; end
      12: begin r = b; zn = 1; end
      13: begin r = ((b * 2) & 255) | (b / 128); zn = 1; end
      14: begin r = (b / 2) | ((b % 2) * 128); zn = 1; end
      15: begin r = ((b * 2) & 255) | c; c = b / 128; zn = 1; end
      16: begin r = (b / 2) | (c * 128); c = b % 2; zn = 1; end
      17: r = ((b % 16) * 16) + (b / 16);
      18: r = b | (1 << bs);
      19: r = b & (255 - (1 << bs));
      20: r = b ^ (1 << bs);
      21: begin e_prod = 16'(w * b); r = (w * b) % 256; end
      22: begin
        lo = w % 16;
        t = w + ((lo > 9 || dc == 1) ? 6 : 0);
        cy1 = (t > 255) ? 1 : 0;
        t = t % 256;
        if ((t / 16) > 9 || c == 1 || cy1 == 1) t = t + 96;
        if (cy1 == 1 || t > 255) c = 1;
        r = t % 256;
        dst = 0;
      end
      default: r = b;
    endcase
    if (arith) begin
      if (add) begin
        t = x + y + k;                 c = (t > 255) ? 1 : 0;
        dc = ((x % 16) + (y % 16) + k > 15) ? 1 : 0;
        s = sx(x) + sx(y) + k;
      end else begin
        t = x - y - k;                 c = (t >= 0) ? 1 : 0;
        dc = ((x % 16) - (y % 16) - k >= 0) ? 1 : 0;
        s = sx(x) - sx(y) - k;
      end
      ov = (s > 127 || s < -128) ? 1 : 0;
      r = (t + 512) % 256;
      zn = 1;
    end
    if (zn) begin z = (r == 0) ? 1 : 0; n = r / 128; end
    e_res = 8'(r);
    e_fl = 5'(c | (dc << 1) | (z << 2) | (ov << 3) | (n << 4));
    e_dest = dst[0];
  endtask

  task automatic compare(input string tag);
    chk(done_o == 1'b1, "R2", "done", int'(done_o), 1);
    chk(res_o == e_res, tag, "result", int'(res_o), int'(e_res));
    chk(flags_o == e_fl, tag, "flags", int'(flags_o), int'(e_fl));
    chk(dest_o == e_dest, "R13", "dest", int'(dest_o), int'(e_dest));
    chk(prod_o == e_prod, "R11", "product", int'(prod_o), int'(e_prod));
  endtask

  task automatic run(input int op, input bit ul, input bit d, input int w, input int f,
                     input int l, input int bs, input int fl);
    @(negedge clk);
    issue_i = 1'b1; op_i = 5'(op); use_lit_i = ul; dest_i = d;
    wreg_i = 8'(w); freg_i = 8'(f); lit_i = 8'(l); bit_sel_i = 3'(bs); flags_i = 5'(fl);
    model(op, w, ul ? l : f, bs, fl, int'(d));
    @(posedge clk); #1;
    compare(tag_of(op));
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    issue_i = 1'b0; op_i = 5'd7; wreg_i = 8'h5A; freg_i = 8'hC3; flags_i = 5'h15; dest_i = ~dest_i;
    @(posedge clk); #1;
    chk(done_o == 1'b0, "R2", "done low when idle", int'(done_o), 0);
    chk(res_o == e_res && flags_o == e_fl && dest_o == e_dest && prod_o == e_prod,
        "R2", "outputs hold when idle", int'(res_o), int'(e_res));
  endtask

  initial begin
    #(CLK_P * 2 + 1);
    chk(done_o == 1'b0 && res_o == 0 && flags_o == 0 && prod_o == 0 && dest_o == 0,
        "R1", "reset state", int'(res_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(done_o == 1'b0 && res_o == 0 && flags_o == 0 && prod_o == 0,
        "R1", "state after reset release", int'(flags_o), 0);

    // Directed corner cases
    run(0, 0, 0, 8'h7F, 8'h01, 0, 0, 0);        // R4 signed overflow, DC
    run(0, 0, 1, 8'hFF, 8'h01, 0, 0, 0);        // R4 carry and zero
    run(1, 1, 0, 8'h0F, 8'h55, 8'h00, 0, 1);    // R3 literal selected, R4 carry-in
    run(2, 0, 0, 8'h02, 8'h10, 0, 0, 0);        // R5 0x10-0x02
    run(2, 0, 0, 8'h10, 8'h02, 0, 0, 0);        // R5 borrow
    run(3, 0, 0, 8'h02, 8'h10, 0, 0, 0);        // R5 borrow in
    run(4, 0, 0, 8'h10, 8'h02, 0, 0, 1);        // R5 reverse no borrow
    run(5, 0, 1, 0, 8'hFF, 0, 0, 0);            // R6 inc wrap
    run(6, 0, 1, 0, 8'h00, 0, 0, 1);            // R6 dec wrap
    run(6, 0, 1, 0, 8'h80, 0, 0, 0);            // R6 dec overflow
    run(7, 0, 1, 0, 8'h80, 0, 0, 0);            // R6 negate 0x80
    run(7, 0, 1, 0, 8'h00, 0, 0, 0);            // R6 negate zero
    run(8, 0, 0, 8'hF0, 8'h0F, 0, 0, 5'h0B);    // R7 AND to zero keeps C/DC/OV
    run(15, 0, 0, 0, 8'h80, 0, 0, 0);           // R8 rotate left through carry
    run(16, 0, 0, 0, 8'h01, 0, 0, 1);           // R8 rotate right through carry
    run(17, 0, 1, 0, 8'hAB, 0, 0, 5'h1F);       // R9 nibble swap
    run(19, 0, 1, 0, 8'hFF, 0, 2, 5'h0A);       // R10 clear bit 2
    run(18, 0, 1, 0, 8'h00, 0, 7, 0);           // R10 set bit 7
    run(20, 1, 1, 0, 0, 8'h81, 0, 0);           // R10 toggle bit 0
    run(21, 0, 0, 8'hFF, 8'hFF, 0, 0, 5'h11);   // R11 max product
    idle_cycle();                               // R2 hold
    run(12, 0, 1, 0, 8'h00, 0, 0, 5'h10);       // R11 product holds across move
    run(22, 0, 1, 8'h9A, 0, 0, 0, 0);           // R12 both corrections, R13 dest forced
    run(22, 0, 0, 8'h12, 0, 0, 0, 2);           // R12 low fix from DC
    run(22, 0, 0, 8'h45, 0, 0, 0, 1);           // R12 high fix from C

    // Pseudo-random sweep compared on every clock
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (lf[31:28] == 4'h0) idle_cycle();
      else run(int'(lf[4:0]) % 23, lf[5], lf[6], int'(lf[14:7]), int'(lf[22:15]),
               int'(lf[30:23]), int'(lf[27:25]), int'(lf[31:27]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule